// File: doc/BRIEF.md
# Half-to-Single Widening Converter

This block turns an IEEE binary16 value into the binary32 value that represents exactly the same number. The conversion logic is purely combinational, and one register stage sits at the output, so a result appears one clock after its input is accepted. Normal inputs need only two steps: the exponent is re-biased and the fraction is padded with zeros. Subnormal inputs go through a priority-encoder leading-zero counter. Its single count sets both the normalizing left shift and the new exponent, so a subnormal half always becomes a normal single.

Zeros, infinities and NaNs keep their sign. A quiet NaN keeps its payload, left-aligned in the wider fraction. A signaling NaN comes out quieted and raises the invalid flag. Every binary16 value fits exactly in binary32, so no rounding happens and no other exception can occur. When the input valid is low, the output word holds its last value.

Top module: `h2s_widen`

## Requirements
- R1: While rst_n is low, out_valid, out_invalid and out_single are all zero.
- R2: out_valid equals the in_valid sampled on the previous rising clock edge.
- R3: Field layout: input sign is bit 15, exponent is bits 14:10 and fraction is bits 9:0; output sign is bit 31, exponent is bits 30:23 and fraction is bits 22:0. For an accepted normal input (exponent 1 to 30), the output exponent is the input exponent plus 112 and the output fraction is the input fraction in bits 22:13, with zeros below.
- R4: For an accepted subnormal input (exponent 0, fraction non-zero), let lz be the number of zeros above the leading one of the 10-bit fraction, counted from bit 9. The output exponent is 112 - lz. The output fraction holds the bits below that leading one, left-aligned at bit 22, with zeros below.
- R5: An accepted zero (exponent 0, fraction 0) gives exponent 0 and fraction 0.
- R6: An accepted infinity (exponent 31, fraction 0) gives exponent 255 and fraction 0.
- R7: An accepted quiet NaN (exponent 31, fraction bit 9 set) gives exponent 255 and the input fraction in bits 22:13 with zeros below, and out_invalid stays 0.
- R8: An accepted signaling NaN (exponent 31, fraction bit 9 clear, fraction non-zero) gives exponent 255, bit 22 set, input fraction bits 8:0 in bits 21:13, zeros below, and out_invalid 1.
- R9: For every accepted input, output bit 31 equals input bit 15.
- R10: out_invalid is 1 only for an accepted signaling NaN. In a cycle after in_valid was low, out_single keeps its previous value and out_invalid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Registered result is present |
| out_single | output | 32 | binary32 result |
| out_invalid | output | 1 | Signaling-NaN input was quieted |

## Verification
A stimulus is driven on a falling edge and captured on the next rising edge. From there, out_valid, out_single and out_invalid all reflect it, so every result is due exactly one clock later. The bench keeps a one-deep expected state that the behavioural model fills when it drives an input. On the following falling edge it compares all three outputs against that state before it drives the next input. With this schedule a class of input (directed corners, then every one of the 65536 codes, with idle cycles carrying junk data mixed in) is always checked in the cycle it is due, never one clock early or late.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

    // binary16 field widths
    localparam int HALF_EXP_W  = 5;
    localparam int HALF_FRAC_W = 10;

    // binary32 field widths
    localparam int SNGL_EXP_W  = 8;
    localparam int SNGL_FRAC_W = 23;

    // one-hot class of a source operand
    typedef struct packed {
        logic zero;
        logic sub;
        logic norm;
        logic inf;
        logic qnan;
        logic snan;
    } h2s_cls_t;

endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
    import h2s_pkg::*;
#(
    parameter int EXP_W  = HALF_EXP_W,
    parameter int FRAC_W = HALF_FRAC_W
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output h2s_cls_t          cls_o
);

    logic exp_zero;
    logic exp_ones;
    logic frac_zero;
    logic quiet_bit;

    always_comb begin
        exp_zero   = (exp_i == '0);
        exp_ones   = &exp_i;
        frac_zero  = (frac_i == '0);
        quiet_bit  = frac_i[FRAC_W-1];

        cls_o.zero = exp_zero & frac_zero;
        cls_o.sub  = exp_zero & ~frac_zero;
        cls_o.norm = ~exp_zero & ~exp_ones;
        cls_o.inf  = exp_ones & frac_zero;
        cls_o.qnan = exp_ones & quiet_bit;
        cls_o.snan = exp_ones & ~quiet_bit & ~frac_zero;
    end

    // every known code falls in exactly one class (supports R3..R8)
    always_comb begin
        if (!$isunknown({exp_i, frac_i})) begin
            assert_class_onehot_R3: assert ($onehot(cls_o));
        end
    end

endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    // priority encoder: the highest set bit wins, so scan upward and let
    // later (higher) hits override earlier ones
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                cnt_o = CW'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/h2s_lshift.sv
module h2s_lshift #(
    parameter int W  = 10,
    parameter int SW = 4
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);

    logic [W-1:0] stage [0:SW];

    assign stage[0] = data_i;

    // logarithmic barrel: stage s shifts by 2**s when amount bit s is set
    for (genvar s = 0; s < SW; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign data_o = stage[SW];

endmodule

// File: rtl/h2s_subnorm.sv
module h2s_subnorm
    import h2s_pkg::*;
#(
    parameter int SRC_FRAC_W = HALF_FRAC_W,
    parameter int DST_EXP_W  = SNGL_EXP_W,
    parameter int DST_FRAC_W = SNGL_FRAC_W,
    parameter int EXP_BASE   = 112
) (
    input  logic [SRC_FRAC_W-1:0] frac_i,
    output logic [DST_EXP_W-1:0]  exp_o,
    output logic [DST_FRAC_W-1:0] frac_o
);

    localparam int CW    = $clog2(SRC_FRAC_W + 1);
    localparam int SW    = $clog2(SRC_FRAC_W + 2);
    localparam int PAD_W = DST_FRAC_W - SRC_FRAC_W;

    logic [CW-1:0]         lz;
    logic [SW-1:0]         amt;
    logic [SRC_FRAC_W-1:0] shifted;

    h2s_lzc #(
        .W  (SRC_FRAC_W),
        .CW (CW)
    ) u_lzc (
        .vec_i (frac_i),
        .cnt_o (lz)
    );

    // one count feeds both the shifter and the exponent
    assign amt = SW'(lz) + SW'(1);

    h2s_lshift #(
        .W  (SRC_FRAC_W),
        .SW (SW)
    ) u_shift (
        .data_i (frac_i),
        .amt_i  (amt),
        .data_o (shifted)
    );

    // the leading one falls off the top of the shifter: it is the hidden bit
    always_comb begin
        exp_o  = DST_EXP_W'(EXP_BASE) - DST_EXP_W'(lz);
        frac_o = {shifted, {PAD_W{1'b0}}};
    end

    always_comb begin
        if (!$isunknown(frac_i) && frac_i != '0) begin
            assert_lz_range_R4: assert (int'(lz) < SRC_FRAC_W);
            assert_lz_hits_one_R4: assert (frac_i[SRC_FRAC_W-1-int'(lz)] == 1'b1);
        end
    end

endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
    import h2s_pkg::*;
#(
    parameter int SRC_EXP_W  = HALF_EXP_W,
    parameter int SRC_FRAC_W = HALF_FRAC_W,
    parameter int DST_EXP_W  = SNGL_EXP_W,
    parameter int DST_FRAC_W = SNGL_FRAC_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [SRC_EXP_W+SRC_FRAC_W:0]      in_half,
    output logic                               out_valid,
    output logic [DST_EXP_W+DST_FRAC_W:0]      out_single,
    output logic                               out_invalid
);

    localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W;
    localparam int DST_W     = 1 + DST_EXP_W + DST_FRAC_W;
    localparam int SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
    localparam int BIAS_DIFF = DST_BIAS - SRC_BIAS;
    localparam int PAD_W     = DST_FRAC_W - SRC_FRAC_W;

    typedef struct packed {
        logic             valid;
        logic             invalid;
        logic [DST_W-1:0] data;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                  src_sign;
    logic [SRC_EXP_W-1:0]  src_exp;
    logic [SRC_FRAC_W-1:0] src_frac;
    h2s_cls_t              cls;
    logic [DST_EXP_W-1:0]  sub_exp;
    logic [DST_FRAC_W-1:0] sub_frac;

    assign src_sign = in_half[SRC_W-1];
    assign src_exp  = in_half[SRC_W-2 -: SRC_EXP_W];
    assign src_frac = in_half[SRC_FRAC_W-1:0];

    h2s_classify #(
        .EXP_W  (SRC_EXP_W),
        .FRAC_W (SRC_FRAC_W)
    ) u_cls (
        .exp_i  (src_exp),
        .frac_i (src_frac),
        .cls_o  (cls)
    );

    h2s_subnorm #(
        .SRC_FRAC_W (SRC_FRAC_W),
        .DST_EXP_W  (DST_EXP_W),
        .DST_FRAC_W (DST_FRAC_W),
        .EXP_BASE   (BIAS_DIFF)
    ) u_sub (
        .frac_i (src_frac),
        .exp_o  (sub_exp),
        .frac_o (sub_frac)
    );

    always_comb begin
        logic [DST_EXP_W-1:0]  res_exp;
        logic [DST_FRAC_W-1:0] res_frac;
        logic                  res_inv;

        res_exp  = '0;
        res_frac = '0;
        res_inv  = 1'b0;

        if (cls.sub) begin
            res_exp  = sub_exp;
            res_frac = sub_frac;
        end else if (cls.norm) begin
            res_exp  = DST_EXP_W'(src_exp) + DST_EXP_W'(BIAS_DIFF);
            res_frac = {src_frac, {PAD_W{1'b0}}};
        end else if (cls.inf) begin
            res_exp  = '1;
        end else if (cls.qnan) begin
            res_exp  = '1;
            res_frac = {src_frac, {PAD_W{1'b0}}};
        end else if (cls.snan) begin
            res_exp  = '1;
            res_frac = {1'b1, src_frac[SRC_FRAC_W-2:0], {PAD_W{1'b0}}};
            res_inv  = 1'b1;
        end

        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.invalid = 1'b0;
        if (in_valid) begin
            st_d.data    = {src_sign, res_exp, res_frac};
            st_d.invalid = res_inv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_single  = st_q.data;
    assign out_invalid = st_q.invalid;

    // ---------------- assertions ----------------
    localparam int OUT_EXP_LO = DST_FRAC_W;
    localparam int OUT_EXP_HI = DST_FRAC_W + DST_EXP_W - 1;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_single[DST_W-1] == $past(in_half[SRC_W-1])));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_single) && !out_invalid));

    assert_invalid_is_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_valid && (&out_single[OUT_EXP_HI:OUT_EXP_LO])
                         && out_single[DST_FRAC_W-1]));

    assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_single[OUT_EXP_HI:OUT_EXP_LO])
         && (out_single[DST_FRAC_W-1:0] != '0)) |-> out_single[DST_FRAC_W-1]);

endmodule

// File: tb/tb_h2s_widen.sv
module tb_h2s_widen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        out_valid;
    logic [31:0] out_single;
    logic        out_invalid;

    int n_chk  = 0;
    int n_fail = 0;

    // expected state, one clock behind the stimulus
    logic        exp_v   = 1'b0;
    logic [31:0] exp_d   = '0;
    logic        exp_inv = 1'b0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    h2s_widen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_half     (in_half),
        .out_valid   (out_valid),
        .out_single  (out_single),
        .out_invalid (out_invalid)
    );

    function automatic logic [31:0] model_widen(input logic [15:0] h);
        logic s;
        int   e;
        int   f;
        int   lz;
        int   m;
        s = h[15];
        e = int'(h[14:10]);
        f = int'(h[9:0]);
        if (e == 0 && f == 0) return {s, 31'b0};
        if (e == 0) begin
            lz = 0;
            while (((f >> (9 - lz)) & 1) == 0) lz++;
            m = (f << (lz + 1)) & 'h3FF;
            return {s, 8'(112 - lz), 10'(m), 13'b0};
        end
        if (e == 31) begin
            if (f == 0) return {s, 8'hFF, 23'b0};
            if ((f & 'h200) != 0) return {s, 8'hFF, 10'(f), 13'b0};
            return {s, 8'hFF, 10'(f | 'h200), 13'b0};
        end
        return {s, 8'(e + 112), 10'(f), 13'b0};
    endfunction

    function automatic string class_tag(input logic [15:0] h);
        if (h[14:10] == 5'd0 && h[9:0] == 10'd0) return "R5 R9";
        if (h[14:10] == 5'd0) return "R4 R9";
        if (h[14:10] != 5'd31) return "R3 R9";
        if (h[9:0] == 10'd0) return "R6 R9";
        if (h[9]) return "R7 R9";
        return "R8 R9";
    endfunction

    function automatic logic is_snan(input logic [15:0] h);
        return (h[14:10] == 5'd31) && !h[9] && (h[8:0] != 9'd0);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare the result of the previous step, then drive the next one
    task automatic step(input logic v, input logic [15:0] h);
        @(negedge clk);
        chk("R2 valid", 32'(out_valid), 32'(exp_v));
        if (exp_v) begin
            chk(exp_tag, out_single, exp_d);
            chk("R8 R10 invalid", 32'(out_invalid), 32'(exp_inv));
        end else begin
            chk("R10 hold data", out_single, exp_d);
            chk("R10 idle invalid", 32'(out_invalid), 32'd0);
        end
        in_valid = v;
        in_half  = h;
        exp_v    = v;
        if (v) begin
            exp_d   = model_widen(h);
            exp_inv = is_snan(h);
            exp_tag = class_tag(h);
        end else begin
            exp_inv = 1'b0;
            exp_tag = "R10";
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // reset with live stimulus: outputs must still read zero (R1)
        in_valid = 1'b1;
        in_half  = 16'h7C01;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(out_valid), 32'd0);
        chk("R1 reset data", out_single, 32'd0);
        chk("R1 reset invalid", 32'(out_invalid), 32'd0);
        in_valid = 1'b0;
        in_half  = '0;
        rst_n    = 1'b1;

        // directed corners
        step(1'b1, 16'h0000);   // +0         R5
        step(1'b1, 16'h8000);   // -0         R5 R9
        step(1'b1, 16'h0001);   // min sub    R4
        step(1'b1, 16'h03FF);   // max sub    R4
        step(1'b1, 16'h8200);   // -sub       R4 R9
        step(1'b1, 16'h0400);   // min normal R3
        step(1'b1, 16'h7BFF);   // max normal R3
        step(1'b1, 16'hBC00);   // -1.0       R3 R9
        step(1'b1, 16'h7C00);   // +inf       R6
        step(1'b1, 16'hFC00);   // -inf       R6 R9
        step(1'b1, 16'h7E00);   // qNaN       R7
        step(1'b1, 16'hFFFF);   // -qNaN      R7
        step(1'b1, 16'h7C01);   // sNaN       R8
        step(1'b1, 16'hFD55);   // -sNaN      R8
        step(1'b0, 16'h1234);   // idle junk  R10
        step(1'b0, 16'h7C01);   // idle sNaN  R10
        step(1'b1, 16'h3C00);   // 1.0
        step(1'b1, 16'h7D00);   // sNaN then idle
        step(1'b0, 16'hABCD);   // R10 invalid must clear

        // every code, with idle cycles woven in
        for (int i = 0; i < 65536; i++) begin
            step(1'b1, 16'(i));
            if (i % 6 == 5) step(1'b0, 16'(i * 7));
        end
        step(1'b0, 16'h0000);
        step(1'b0, 16'h0000);

        summary();
        $finish;
    end

endmodule